// File: doc/BRIEF.md
# Opcode-Selected Byte ALU

This block is a purely combinational arithmetic and logic unit for an 8-bit datapath. It takes the full 8-bit opcode byte of an arithmetic instruction together with two 8-bit operands. Within the same cycle it returns an 8-bit result and a flag that says whether the opcode named a supported operation. The low nibble of the opcode selects one of eleven operations: wrapping add and subtract, three bitwise logic functions, a one-operand complement, logical shifts in both directions, rotates in both directions, and a multiply that keeps only the low byte of the product.

The two top opcode bits select the operand sources in the surrounding instruction decoder. They play no part here. The two bits below them mark the opcode as arithmetic and must be zero. Any opcode outside the supported set gives a zero result with the valid flag low, so the caller can gate its register write-back on the flag alone. No carry, overflow or comparison flags are produced.

Top module: `opcode_alu`

## Requirements
- R1: With opcode bits [5:4] = 00 and bits [3:0] = 0, the result is (opA + opB) mod 256 and opValid is 1.
- R2: With bits [3:0] = 1, the result is (opA - opB) mod 256 and opValid is 1.
- R3: Bits [3:0] = 2, 3 and 5 give opA AND opB, opA OR opB and opA XOR opB respectively.
- R4: Bits [3:0] = 4 give the bitwise complement of opA, and opB has no effect on the result.
- R5: Bits [3:0] = 6 shift opA left by opB[2:0] places and fill with zeros; opB[7:3] has no effect on the shift.
- R6: Bits [3:0] = 7 shift opA right logically by opB[2:0] places and fill the top with zeros.
- R7: Bits [3:0] = 8 rotate opA left and bits [3:0] = 9 rotate opA right, each by opB[2:0] places, so bits leaving one end re-enter at the other.
- R8: Bits [3:0] = 10 give the low 8 bits of the product opA * opB; higher product bits are discarded.
- R9: Bits [3:0] = 11 to 15 give result 0 and opValid 0.
- R10: Any opcode whose bits [5:4] are not 00 gives result 0 and opValid 0, whatever the low nibble.
- R11: Opcode bits [7:6] have no effect on result or opValid.
- R12: opValid is 1 exactly when bits [5:4] are 00 and bits [3:0] are 10 or less, and a zero opcode with zero operands gives result 0 with opValid 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 8 | Full opcode byte; [3:0] selects the operation, [5:4] must be 00, [7:6] ignored |
| opA | input | 8 | First operand (the only operand of the complement) |
| opB | input | 8 | Second operand; [2:0] is the shift and rotate amount |
| result | output | 8 | Operation result, 0 when the opcode is not supported |
| opValid | output | 1 | High when the opcode names a supported operation |

## Verification
The block holds no state, so a fault in its decoder or in any unit appears at the result and valid ports in the same cycle as the stimulus. A strobe decoded wrongly shows as a result from the wrong unit, or as two units' results merged by OR. A wrong amount bit in the shifter shows only for amounts that use that stage, which is why every stage is driven on its own and also driven above the 3-bit field. An operation that is checked against a legal code but not against its illegal neighbours could hide a decoder that accepts too much. For this reason the unused codes and the marker bits are checked for a zero result as well as a low flag.

// File: rtl/opcode_alu_pkg.sv
package opcode_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_NOT = 4'd4,
    OP_XOR = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9,
    OP_MUL = 4'd10
  } aluOp_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2,
    LF_NOT = 2'd3
  } logicFn_e;

  // Strobes from the decoder to the datapath; at most one unit enable is high.
  typedef struct packed {
    logic     addEn;
    logic     subMode;
    logic     logicEn;
    logicFn_e logicFn;
    logic     shiftEn;
    logic     shiftRight;
    logic     rotate;
    logic     mulEn;
    logic     opValid;
  } aluStrobe_t;

endpackage

// File: rtl/opcode_alu_ctrl.sv
module opcode_alu_ctrl
  import opcode_alu_pkg::*;
(
  input  logic [5:0]  opBits,
  output aluStrobe_t  strobe
);

  logic arithClass;
  assign arithClass = (opBits[5:4] == 2'b00);

  always_comb begin
    strobe = '0;
    if (arithClass) begin
      case (aluOp_e'(opBits[3:0]))
        OP_ADD: begin strobe.addEn = 1'b1; strobe.opValid = 1'b1; end
        OP_SUB: begin strobe.addEn = 1'b1; strobe.subMode = 1'b1; strobe.opValid = 1'b1; end
        OP_AND: begin strobe.logicEn = 1'b1; strobe.logicFn = LF_AND; strobe.opValid = 1'b1; end
        OP_OR:  begin strobe.logicEn = 1'b1; strobe.logicFn = LF_OR;  strobe.opValid = 1'b1; end
        OP_XOR: begin strobe.logicEn = 1'b1; strobe.logicFn = LF_XOR; strobe.opValid = 1'b1; end
        OP_NOT: begin strobe.logicEn = 1'b1; strobe.logicFn = LF_NOT; strobe.opValid = 1'b1; end
        OP_SHL: begin strobe.shiftEn = 1'b1; strobe.opValid = 1'b1; end
        OP_SHR: begin strobe.shiftEn = 1'b1; strobe.shiftRight = 1'b1; strobe.opValid = 1'b1; end
        OP_ROL: begin strobe.shiftEn = 1'b1; strobe.rotate = 1'b1; strobe.opValid = 1'b1; end
        OP_ROR: begin
          strobe.shiftEn    = 1'b1;
          strobe.shiftRight = 1'b1;
          strobe.rotate     = 1'b1;
          strobe.opValid    = 1'b1;
        end
        OP_MUL: begin strobe.mulEn = 1'b1; strobe.opValid = 1'b1; end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/opcode_alu_datapath.sv
module opcode_alu_datapath
  import opcode_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobe_t        strobe,
  output logic [DATA_W-1:0] result
);

  localparam int SHAMT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  // Shared adder: subtract is add of the complement plus one.
  logic [DATA_W-1:0] addOperand;
  logic [DATA_W-1:0] sumOut;
  always_comb begin
    addOperand = strobe.subMode ? ~opB : opB;
    sumOut     = opA + addOperand + {{(DATA_W-1){1'b0}}, strobe.subMode};
  end

  // Bitwise unit.
  logic [DATA_W-1:0] logicOut;
  always_comb begin
    case (strobe.logicFn)
      LF_AND:  logicOut = opA & opB;
      LF_OR:   logicOut = opA | opB;
      LF_XOR:  logicOut = opA ^ opB;
      default: logicOut = ~opA;
    endcase
  end

  // Shifter: one left-going log stage network; right-going ops reverse bits around it.
  logic [DATA_W-1:0] aRev;
  logic [DATA_W-1:0] stageIn;
  logic [DATA_W-1:0] stage [0:SHAMT_W];
  logic [DATA_W-1:0] stageRev;
  logic [DATA_W-1:0] shiftOut;
  logic [SHAMT_W-1:0] shAmt;

  assign shAmt = opB[SHAMT_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign aRev[i]     = opA[DATA_W-1-i];
    assign stageRev[i] = stage[SHAMT_W][DATA_W-1-i];
  end

  assign stageIn  = strobe.shiftRight ? aRev : opA;
  assign stage[0] = stageIn;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    logic [DIST-1:0] fillBits;
    assign fillBits = strobe.rotate ? stage[s][DATA_W-1:DATA_W-DIST] : '0;
    assign stage[s+1] = shAmt[s] ? {stage[s][DATA_W-1-DIST:0], fillBits} : stage[s];
  end

  assign shiftOut = strobe.shiftRight ? stageRev : stage[SHAMT_W];

  // Truncating multiplier: sum of shifted partial products, kept at DATA_W bits.
  logic [DATA_W-1:0] mulOut;
  always_comb begin
    mulOut = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (opB[i]) mulOut = mulOut + (opA << i);
    end
  end

  // AND-OR result mux; all enables low gives zero.
  assign result = ({DATA_W{strobe.addEn}}   & sumOut)
                | ({DATA_W{strobe.logicEn}} & logicOut)
                | ({DATA_W{strobe.shiftEn}} & shiftOut)
                | ({DATA_W{strobe.mulEn}}   & mulOut);

endmodule

// File: rtl/opcode_alu.sv
module opcode_alu
  import opcode_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [7:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              opValid
);

  aluStrobe_t strobe;
  logic unusedSrcSel;

  // Operand source selects belong to the instruction decoder.
  assign unusedSrcSel = ^opCode[7:6];

  opcode_alu_ctrl u_ctrl (
    .opBits (opCode[5:0]),
    .strobe (strobe)
  );

  opcode_alu_datapath #(.DATA_W(DATA_W)) u_datapath (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result)
  );

  assign opValid = strobe.opValid;

endmodule

// File: rtl/opcode_alu_checker.sv
module opcode_alu_checker #(
  parameter int DATA_W = 8
) (
  input logic [7:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic              opValid
);

  logic [3:0] code;
  logic       legalClass;
  logic [DATA_W-1:0] diffOut;
  logic [DATA_W-1:0] sumBack;
  assign code       = opCode[3:0];
  assign legalClass = (opCode[5:4] == 2'b00);
  assign diffOut    = result - opA;
  assign sumBack    = result + opB;

  always_comb begin
    if (legalClass && code == 4'd0)
      assert_add_wrap_R1: assert (diffOut == opB) else $error("add result mismatch");
    if (legalClass && code == 4'd1)
      assert_sub_wrap_R2: assert (sumBack == opA) else $error("sub result mismatch");
    if (legalClass && code == 4'd5)
      assert_xor_undo_R3: assert ((result ^ opB) == opA) else $error("xor result mismatch");
    if (legalClass && code == 4'd4)
      assert_not_inverse_R4: assert ((result ^ opA) == {DATA_W{1'b1}}) else $error("not mismatch");
    if (legalClass && code == 4'd6 && opB[2:0] == 3'd0)
      assert_shl_zero_amt_R5: assert (result == opA) else $error("shl by zero changed data");
    if (legalClass && code == 4'd7 && opB[2:0] != 3'd0)
      assert_shr_msb_clear_R6: assert (result[DATA_W-1] == 1'b0) else $error("shr top not zero");
    if (legalClass && (code == 4'd8 || code == 4'd9))
      assert_rot_keeps_ones_R7: assert ($countones(result) == $countones(opA)) else $error("rotate lost bits");
    if (legalClass && code == 4'd10 && opB == {{(DATA_W-1){1'b0}}, 1'b1})
      assert_mul_identity_R8: assert (result == opA) else $error("mul by one mismatch");
    if (!opValid)
      assert_idle_zero_R9: assert (result == '0) else $error("invalid op gave nonzero result");
    if (!legalClass)
      assert_class_reject_R10: assert (!opValid) else $error("non-arith opcode flagged valid");
    assert_valid_map_R12: assert (opValid == (legalClass && code <= 4'd10)) else $error("valid map wrong");
  end

endmodule

bind opcode_alu opcode_alu_checker #(.DATA_W(DATA_W)) u_checker (
  .opCode  (opCode),
  .opA     (opA),
  .opB     (opB),
  .result  (result),
  .opValid (opValid)
);

// File: tb/opcode_alu_bench.sv
module opcode_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] opCode = '0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [7:0] result;
  logic       opValid;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;

  typedef struct {
    logic [7:0] code;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] expRes;
    logic       expValid;
    string      tag;
  } item_t;

  item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  opcode_alu u_opcode_alu (
    .opCode  (opCode),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .opValid (opValid)
  );

  // Reference model written from the requirements.
  function automatic logic expValidOf(input logic [7:0] c);
    return (c[5:4] == 2'b00) && (c[3:0] <= 4'd10);
  endfunction

  function automatic logic [7:0] expResultOf(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
    logic [15:0] wide;
    int n;
    n = int'(b[2:0]);
    if (!expValidOf(c)) return 8'h00;
    case (c[3:0])
      4'd0: return 8'((int'(a) + int'(b)) % 256);
      4'd1: return 8'((int'(a) - int'(b) + 256) % 256);
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return ~a;
      4'd5: return a ^ b;
      4'd6: return 8'(a << n);
      4'd7: return a >> n;
      4'd8: begin wide = {a, a} << n; return wide[15:8]; end
      4'd9: begin wide = {a, a} >> n; return wide[7:0]; end
      default: begin wide = 16'(a) * 16'(b); return wide[7:0]; end
    endcase
  endfunction

  task automatic drive(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] er, input logic ev, input string tag);
    item_t it;
    @(posedge clk);
    opCode = c;
    opA    = a;
    opB    = b;
    it.code = c; it.a = a; it.b = b; it.expRes = er; it.expValid = ev; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic driveModel(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b, input string tag);
    drive(c, a, b, expResultOf(c, a, b), expValidOf(c), tag);
  endtask

  // Monitor: compare at the falling edge, half a period after inputs change.
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (result !== it.expRes || opValid !== it.expValid) begin
        errors++;
        $display("FAIL %s: op=%02h a=%02h b=%02h actual res=%02h valid=%0b expected res=%02h valid=%0b",
                 it.tag, it.code, it.a, it.b, result, opValid, it.expRes, it.expValid);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    drive(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R12 reset-state zero opcode");
    drive(8'h00, 8'd200, 8'd100, 8'h2C, 1'b1, "R1 add wraps");
    drive(8'h00, 8'hFF, 8'h01, 8'h00, 1'b1, "R1 add carry out dropped");
    drive(8'h01, 8'd5, 8'd9, 8'hFC, 1'b1, "R2 sub wraps");
    drive(8'h01, 8'h80, 8'h01, 8'h7F, 1'b1, "R2 sub");
    drive(8'h02, 8'hA5, 8'h3C, 8'h24, 1'b1, "R3 and");
    drive(8'h03, 8'hA5, 8'h3C, 8'hBD, 1'b1, "R3 or");
    drive(8'h05, 8'hA5, 8'h3C, 8'h99, 1'b1, "R3 xor");
    drive(8'h04, 8'h5A, 8'hFF, 8'hA5, 1'b1, "R4 not with b=FF");
    drive(8'h04, 8'h5A, 8'h00, 8'hA5, 1'b1, "R4 not with b=00");
    drive(8'h06, 8'h81, 8'h0B, 8'h08, 1'b1, "R5 shl amount from low bits");
    drive(8'h06, 8'hFF, 8'h07, 8'h80, 1'b1, "R5 shl by 7");
    drive(8'h06, 8'h81, 8'h08, 8'h81, 1'b1, "R5 shl amount 8 is zero");
    drive(8'h07, 8'h80, 8'h0F, 8'h01, 1'b1, "R6 shr logical by 7");
    drive(8'h07, 8'hF0, 8'h02, 8'h3C, 1'b1, "R6 shr zero fill");
    drive(8'h08, 8'h81, 8'h01, 8'h03, 1'b1, "R7 rol by 1");
    drive(8'h08, 8'h96, 8'h04, 8'h69, 1'b1, "R7 rol by 4");
    drive(8'h09, 8'h81, 8'h09, 8'hC0, 1'b1, "R7 ror amount from low bits");
    drive(8'h09, 8'h01, 8'h02, 8'h40, 1'b1, "R7 ror by 2");
    drive(8'h0A, 8'h10, 8'h11, 8'h10, 1'b1, "R8 mul truncates");
    drive(8'h0A, 8'hFF, 8'hFF, 8'h01, 1'b1, "R8 mul max");
    drive(8'h0A, 8'h0D, 8'h0B, 8'h8F, 1'b1, "R8 mul small");
    for (int c = 11; c < 16; c++)
      drive(8'(c), 8'hFF, 8'hFF, 8'h00, 1'b0, "R9 unused code");
    drive(8'h10, 8'h12, 8'h34, 8'h00, 1'b0, "R10 bit4 set");
    drive(8'h20, 8'h12, 8'h34, 8'h00, 1'b0, "R10 bit5 set");
    drive(8'h3A, 8'h12, 8'h34, 8'h00, 1'b0, "R10 both set on mul");
    drive(8'hC0, 8'h01, 8'h02, 8'h03, 1'b1, "R11 add with bits76=11");
    drive(8'h41, 8'h09, 8'h05, 8'h04, 1'b1, "R11 sub with bits76=01");
    drive(8'h8A, 8'h03, 8'h07, 8'h15, 1'b1, "R11 mul with bits76=10");
    drive(8'hCB, 8'hFF, 8'hFF, 8'h00, 1'b0, "R11 unused code with bits76=11");

    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [7:0] c;
      logic [7:0] a;
      logic [7:0] b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[7:0];
      b = lfsr[15:8] ^ 8'(k);
      c = {lfsr[3:2], (k % 8 == 0) ? lfsr[5:4] : 2'b00, 4'(k % 16)};
      driveModel(c, a, b, "R12 sweep all codes");
    end

    repeat (3) @(posedge clk);
    doneFlag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule